// File: doc/BRIEF.md
# Sector Program Host Sequencer

This block sits on the host side of a byte-wide parallel nonvolatile memory and programs one sector per operation. A request carries a sector number and a flag that asks for the protection unlock. When the flag is set, the block first drives a fixed three-write key sequence on the memory bus. It then accepts a stream of offset/data pairs and turns each one into a bus write inside the chosen sector. Offsets may come in any order. The device fills every byte that is not loaded with FFh, and no erase command is ever issued.

After the final byte has been written, the block waits out the device's internal write cycle with a cycle counter and then pulses `done_o` together with an error code. Each bus write is framed by chip enable and uses a write-enable pulse whose width, in clocks, is a parameter. Output enable stays inactive because the read path is out of scope.

A parameter selects the address layout: 512-byte sectors (offset in address bits 8:0, sector in 18:9) or 256-byte sectors (offset in 7:0, sector in 18:8). An idle-gap limit closes the load phase if the host stalls, so that the device is never left to begin its cycle while the host still believes it is loading.

Top module: `spg_sector_writer`

## Requirements
- R1: While reset is held and after it is released, `busy_o`, `done_o` and `byte_ready_o` are 0 and `mem_ce_n_o`, `mem_we_n_o` and `mem_oe_n_o` are 1.
- R2: When `req_unlock_i` is 1, the first three bus writes of the operation are data AAh at address 05555h, then 55h at 02AAAh, then A0h at 05555h, in that order. When it is 0, no such writes are issued.
- R3: Each accepted in-range byte produces one bus write. Its address is the latched sector number concatenated with the offset, and its data is the byte. The sector part of the address stays constant for the whole operation.
- R4: Each bus write holds `mem_we_n_o` low for exactly WE_CLKS consecutive clocks. `mem_ce_n_o` is low whenever `mem_we_n_o` is low. Address and data do not change while `mem_ce_n_o` stays low. `mem_oe_n_o` is always 1.
- R5: A byte whose offset is at least the sector size (512, or 256 in the alternate layout) produces no bus write. The operation finishes with `err_o` bit 0 set.
- R6: If the load phase spends GAP_MAX consecutive clocks without an in-range byte write, it closes. `done_o` then follows GAP_MAX+TWC_CLKS+1 clocks after the rising edge of the last write strobe, with `err_o` bit 1 set.
- R7: `done_o` is a one-clock pulse TWC_CLKS+1 clocks after the rising edge of the final byte's write strobe. `busy_o` is 1 from the clock after the request through the `done_o` clock, and 0 after it.
- R8: An operation issues only the key writes and the in-range byte writes, in the order the bytes were accepted, and no other bus cycle.
- R9: With SECTOR_512 = 0, the offset occupies address bits 7:0 and the 11-bit sector occupies bits 18:8.
- R10: `byte_ready_o` is 1 only in the load phase while no bus write is in progress. A request that arrives while `busy_o` is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Starts an operation when idle |
| req_sector_i | input | SEC_W | Sector number (10 bits by default) |
| req_unlock_i | input | 1 | Issue the three-write key sequence first |
| byte_valid_i | input | 1 | Offered byte is valid |
| byte_last_i | input | 1 | Offered byte ends the load phase |
| byte_offset_i | input | OFFIN_W | Byte offset within the sector |
| byte_data_i | input | DATA_W | Byte value |
| byte_ready_o | output | 1 | Byte is taken when valid and ready are both 1 |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-clock completion pulse |
| err_o | output | 2 | Bit 0: offset out of range; bit 1: gap timeout. Valid with `done_o` |
| mem_addr_o | output | ADDR_W | Memory address bus |
| mem_data_o | output | DATA_W | Memory data bus |
| mem_ce_n_o | output | 1 | Chip enable, active low |
| mem_oe_n_o | output | 1 | Output enable, active low, held inactive |
| mem_we_n_o | output | 1 | Write enable, active low |

## Verification
The bench builds two instances. The first uses 512-byte sectors, a 3-clock write strobe, a 24-clock gap limit and a 150-clock write-cycle wait. These short windows let the gap timeout and the full post-load wait run to expiry within a few hundred clocks, and the first instance carries the key sequence, random-order offsets, out-of-range offsets and a request arriving while busy. The second uses 256-byte sectors and a 1-clock strobe. This selects the single-cycle strobe variant and makes offset 100h fall outside the sector, which is in range for the first layout.

// File: rtl/spg_pkg.sv
package spg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_KEY,
      ST_KEY_W,
      ST_LOAD,
      ST_BWR,
      ST_TWC,
      ST_DONE
   } seq_state_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_SETUP,
      PH_PULSE,
      PH_HOLD
   } bus_phase_e;

   typedef struct packed {
      logic gap;
      logic range;
   } op_err_t;

   localparam logic [1:0] KEY_LAST_STEP = 2'd2;

   // key sequence address per step
   function automatic logic [15:0] key_addr(input logic [1:0] step);
      return (step == 2'd1) ? 16'h2AAA : 16'h5555;
   endfunction

   // key sequence data per step
   function automatic logic [7:0] key_data(input logic [1:0] step);
      case (step)
         2'd0:    return 8'hAA;
         2'd1:    return 8'h55;
         default: return 8'hA0;
      endcase
   endfunction

endpackage

// File: rtl/spg_cycle_timer.sv
module spg_cycle_timer #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   output logic expired_o
);
   localparam int CW = $clog2(LIMIT + 1);

   logic [CW-1:0] cnt;

   assign expired_o = run_i && (cnt == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (!run_i)             cnt <= '0;
      else if (!expired_o)         cnt <= cnt + CW'(1);
   end

   // R6 / R7: the count never passes the window it measures
   a_r7_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(LIMIT - 1));

endmodule

// File: rtl/spg_bus_strobe.sv
module spg_bus_strobe
   import spg_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int DATA_W  = 8,
   parameter int WE_CLKS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [DATA_W-1:0] mem_data_o,
   output logic              mem_ce_n_o,
   output logic              mem_we_n_o
);
   localparam int PW_W = $clog2(WE_CLKS + 1);

   bus_phase_e        ph;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;
   logic              pulse_last;

   generate
      if (WE_CLKS == 1) begin : g_pulse_one
         assign pulse_last = 1'b1;
      end else begin : g_pulse_multi
         logic [PW_W-1:0] pcnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                pcnt <= '0;
            else if (ph != PH_PULSE)   pcnt <= '0;
            else                       pcnt <= pcnt + PW_W'(1);
         end
         assign pulse_last = (pcnt == PW_W'(WE_CLKS - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph     <= PH_IDLE;
         addr_q <= '0;
         data_q <= '0;
      end else begin
         case (ph)
            PH_IDLE: if (start_i) begin
               ph     <= PH_SETUP;
               addr_q <= addr_i;
               data_q <= data_i;
            end
            PH_SETUP: ph <= PH_PULSE;
            PH_PULSE: if (pulse_last) ph <= PH_HOLD;
            default:  ph <= PH_IDLE;
         endcase
      end
   end

   assign busy_o     = (ph != PH_IDLE);
   assign done_o     = (ph == PH_HOLD);
   assign mem_addr_o = addr_q;
   assign mem_data_o = data_q;
   assign mem_ce_n_o = (ph == PH_IDLE);
   assign mem_we_n_o = (ph != PH_PULSE);

   // R4: address and data are steady for the whole selected window
   a_r4_bus_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n_o && $past(!mem_ce_n_o)) |-> ($stable(mem_addr_o) && $stable(mem_data_o)));

   // R4: the write strobe only falls after a selected setup cycle
   a_r4_setup_before_we: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mem_we_n_o) |-> $past(!mem_ce_n_o));

   // R4: after the strobe rises, chip enable is still low for one hold cycle
   a_r4_hold_after_we: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n_o) |-> !mem_ce_n_o);

   // R10: a new write is never requested while one is running
   a_r10_start_when_free: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |-> !busy_o);

endmodule

// File: rtl/spg_seq_ctrl.sv
module spg_seq_ctrl
   import spg_pkg::*;
#(
   parameter int ADDR_W  = 19,
   parameter int DATA_W  = 8,
   parameter int OFF_W   = 9,
   parameter int OFFIN_W = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   input  logic [ADDR_W-OFF_W-1:0] req_sector_i,
   input  logic               req_unlock_i,
   input  logic               byte_valid_i,
   input  logic               byte_last_i,
   input  logic [OFFIN_W-1:0] byte_offset_i,
   input  logic [DATA_W-1:0]  byte_data_i,
   output logic               byte_ready_o,
   output logic               bus_start_o,
   output logic [ADDR_W-1:0]  bus_addr_o,
   output logic [DATA_W-1:0]  bus_data_o,
   input  logic               bus_busy_i,
   input  logic               bus_done_i,
   output logic               gap_run_o,
   input  logic               gap_expired_i,
   output logic               twc_run_o,
   input  logic               twc_expired_i,
   output logic               busy_o,
   output logic               done_o,
   output logic [1:0]         err_o
);
   localparam int SEC_W        = ADDR_W - OFF_W;
   localparam int SECTOR_BYTES = 1 << OFF_W;

   seq_state_e       st;
   logic [SEC_W-1:0] sec_q;
   logic [1:0]       step_q;
   logic             last_q;
   op_err_t          err_q;
   logic             accept;
   logic             in_range;

   assign byte_ready_o = (st == ST_LOAD) && !gap_expired_i;
   assign accept       = byte_valid_i && byte_ready_o;
   assign in_range     = (byte_offset_i < OFFIN_W'(SECTOR_BYTES));

   assign bus_start_o = (st == ST_KEY) || (accept && in_range);
   assign bus_addr_o  = (st == ST_KEY) ? ADDR_W'(key_addr(step_q))
                                       : {sec_q, byte_offset_i[OFF_W-1:0]};
   assign bus_data_o  = (st == ST_KEY) ? DATA_W'(key_data(step_q)) : byte_data_i;

   assign gap_run_o = (st == ST_LOAD);
   assign twc_run_o = (st == ST_TWC);
   assign busy_o    = (st != ST_IDLE);
   assign done_o    = (st == ST_DONE);
   assign err_o     = err_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         sec_q  <= '0;
         step_q <= '0;
         last_q <= 1'b0;
         err_q  <= '0;
      end else begin
         case (st)
            ST_IDLE: if (req_valid_i) begin
               sec_q  <= req_sector_i;
               step_q <= '0;
               last_q <= 1'b0;
               err_q  <= '0;
               st     <= req_unlock_i ? ST_KEY : ST_LOAD;
            end
            ST_KEY: st <= ST_KEY_W;
            ST_KEY_W: if (bus_done_i) begin
               if (step_q == KEY_LAST_STEP) begin
                  st <= ST_LOAD;
               end else begin
                  step_q <= step_q + 2'd1;
                  st     <= ST_KEY;
               end
            end
            ST_LOAD: begin
               if (gap_expired_i) begin
                  err_q.gap <= 1'b1;
                  st        <= ST_TWC;
               end else if (accept) begin
                  if (in_range) begin
                     last_q <= byte_last_i;
                     st     <= ST_BWR;
                  end else begin
                     err_q.range <= 1'b1;
                     if (byte_last_i) st <= ST_TWC;
                  end
               end
            end
            ST_BWR: if (bus_done_i) st <= last_q ? ST_TWC : ST_LOAD;
            ST_TWC: if (twc_expired_i) st <= ST_DONE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R3: the latched sector cannot move during an operation
   a_r3_sector_held: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE && $past(st) != ST_IDLE) |-> $stable(sec_q));

   // R7: done lasts one clock and the block is idle afterwards
   a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o));

   // R5: a rejected offset leaves the bus idle
   a_r5_oob_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !in_range) |=> !bus_busy_i);

   // R6: a gap timeout moves to the wait and records the error
   a_r6_gap_closes_load: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_LOAD && gap_expired_i) |=> (st == ST_TWC && err_q.gap));

   // R2: the load phase is reached from the key sequence only after its third write
   a_r2_key_complete: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == ST_KEY_W && st == ST_LOAD) |-> ($past(step_q) == KEY_LAST_STEP));

endmodule

// File: rtl/spg_sector_writer.sv
module spg_sector_writer #(
   parameter int ADDR_W     = 19,
   parameter int DATA_W     = 8,
   parameter bit SECTOR_512 = 1'b1,
   parameter int OFFIN_W    = 10,
   parameter int WE_CLKS    = 2,
   parameter int GAP_MAX    = 1000,
   parameter int TWC_CLKS   = 1000000,
   localparam int OFF_W     = SECTOR_512 ? 9 : 8,
   localparam int SEC_W     = ADDR_W - OFF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid_i,
   input  logic [SEC_W-1:0]   req_sector_i,
   input  logic               req_unlock_i,
   input  logic               byte_valid_i,
   input  logic               byte_last_i,
   input  logic [OFFIN_W-1:0] byte_offset_i,
   input  logic [DATA_W-1:0]  byte_data_i,
   output logic               byte_ready_o,
   output logic               busy_o,
   output logic               done_o,
   output logic [1:0]         err_o,
   output logic [ADDR_W-1:0]  mem_addr_o,
   output logic [DATA_W-1:0]  mem_data_o,
   output logic               mem_ce_n_o,
   output logic               mem_oe_n_o,
   output logic               mem_we_n_o
);
   generate
      if (ADDR_W < 15) begin : g_chk_addr
         $error("ADDR_W must cover the key addresses (>= 15)");
      end
      if (DATA_W < 8) begin : g_chk_data
         $error("DATA_W must hold the key bytes (>= 8)");
      end
      if (OFFIN_W <= OFF_W) begin : g_chk_offin
         $error("OFFIN_W must exceed the in-sector offset width");
      end
      if (WE_CLKS < 1 || GAP_MAX < 1 || TWC_CLKS < 1) begin : g_chk_time
         $error("strobe width, gap limit and wait must be at least one clock");
      end
   endgenerate

   logic              bus_start, bus_busy, bus_done;
   logic [ADDR_W-1:0] bus_addr;
   logic [DATA_W-1:0] bus_data;
   logic              gap_run, gap_expired, twc_run, twc_expired;

   spg_seq_ctrl #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .OFF_W  (OFF_W),
      .OFFIN_W(OFFIN_W)
   ) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid_i),
      .req_sector_i (req_sector_i),
      .req_unlock_i (req_unlock_i),
      .byte_valid_i (byte_valid_i),
      .byte_last_i  (byte_last_i),
      .byte_offset_i(byte_offset_i),
      .byte_data_i  (byte_data_i),
      .byte_ready_o (byte_ready_o),
      .bus_start_o  (bus_start),
      .bus_addr_o   (bus_addr),
      .bus_data_o   (bus_data),
      .bus_busy_i   (bus_busy),
      .bus_done_i   (bus_done),
      .gap_run_o    (gap_run),
      .gap_expired_i(gap_expired),
      .twc_run_o    (twc_run),
      .twc_expired_i(twc_expired),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .err_o        (err_o)
   );

   spg_bus_strobe #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .WE_CLKS(WE_CLKS)
   ) u_bus (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (bus_start),
      .addr_i    (bus_addr),
      .data_i    (bus_data),
      .busy_o    (bus_busy),
      .done_o    (bus_done),
      .mem_addr_o(mem_addr_o),
      .mem_data_o(mem_data_o),
      .mem_ce_n_o(mem_ce_n_o),
      .mem_we_n_o(mem_we_n_o)
   );

   spg_cycle_timer #(.LIMIT(GAP_MAX)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (gap_run),
      .expired_o(gap_expired)
   );

   spg_cycle_timer #(.LIMIT(TWC_CLKS)) u_twc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (twc_run),
      .expired_o(twc_expired)
   );

   assign mem_oe_n_o = 1'b1;

   // R1 / R4: no write strobe outside an operation
   a_r4_we_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n_o |-> busy_o);

endmodule

// File: tb/sim_spg_sector_writer.sv
module sim_spg_sector_writer;
   localparam int AW = 19;
   localparam int OIW = 10;
   localparam int A_WE = 3, A_GAP = 24, A_TWC = 150;
   localparam int B_WE = 1, B_GAP = 24, B_TWC = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   int checks = 0, fails = 0, cyc = 0;
   bit finished = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // ---------------- instance u0: 512-byte sectors ----------------
   logic a_req = 0, a_unlk = 0, a_bv = 0, a_last = 0;
   logic [9:0] a_sec = '0;
   logic [OIW-1:0] a_off = '0;
   logic [7:0] a_dat = '0;
   logic a_rdy, a_busy, a_done, a_ce, a_oe, a_we;
   logic [1:0] a_err;
   logic [AW-1:0] a_maddr;
   logic [7:0] a_mdat;

   spg_sector_writer #(.SECTOR_512(1'b1), .OFFIN_W(OIW), .WE_CLKS(A_WE),
                       .GAP_MAX(A_GAP), .TWC_CLKS(A_TWC)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid_i(a_req), .req_sector_i(a_sec),
      .req_unlock_i(a_unlk), .byte_valid_i(a_bv), .byte_last_i(a_last),
      .byte_offset_i(a_off), .byte_data_i(a_dat), .byte_ready_o(a_rdy),
      .busy_o(a_busy), .done_o(a_done), .err_o(a_err), .mem_addr_o(a_maddr),
      .mem_data_o(a_mdat), .mem_ce_n_o(a_ce), .mem_oe_n_o(a_oe), .mem_we_n_o(a_we));

   // scoreboard of expected bus writes
   logic [AW-1:0] qa[$];
   logic [7:0]    qd[$];
   string         qt[$];

   task automatic push_exp(input logic [AW-1:0] a, input logic [7:0] d, input string t);
      qa.push_back(a); qd.push_back(d); qt.push_back(t);
   endtask

   logic a_we_prev = 1'b1, a_ce_prev = 1'b1;
   logic [AW-1:0] a_addr_prev = '0;
   logic [7:0] a_dat_prev = '0;
   int a_low = 0, last_rise = 0, stab_viol = 0, ce_viol = 0, oe_viol = 0;
   bit a_done_hit = 1'b0;
   int a_done_cyc = 0;
   logic [1:0] a_done_err = '0;
   logic [AW-1:0] ea;
   logic [7:0] ed;
   string et;

   // monitor: pops the scoreboard on every completed write strobe
   always @(negedge clk) begin
      if (rst_n) begin
         if (a_oe !== 1'b1) oe_viol++;
         if (a_we === 1'b0 && a_ce !== 1'b0) ce_viol++;
         if (a_ce === 1'b0 && a_ce_prev === 1'b0 &&
             (a_maddr !== a_addr_prev || a_mdat !== a_dat_prev)) stab_viol++;
         if (a_we === 1'b0) a_low++;
         if (a_we === 1'b1 && a_we_prev === 1'b0) begin
            last_rise = cyc;
            chk(a_low == A_WE, "R4", "write strobe width", a_low, A_WE);
            a_low = 0;
            if (qa.size() == 0) begin
               chk(1'b0, "R8", "unexpected bus write", a_maddr, 0);
            end else begin
               ea = qa.pop_front(); ed = qd.pop_front(); et = qt.pop_front();
               chk(a_maddr == ea, et, "write address", a_maddr, ea);
               chk(a_mdat == ed, et, "write data", a_mdat, ed);
            end
         end
         if (a_done === 1'b1) begin
            a_done_hit = 1'b1; a_done_cyc = cyc; a_done_err = a_err;
         end
         a_we_prev = a_we; a_ce_prev = a_ce; a_addr_prev = a_maddr; a_dat_prev = a_mdat;
      end
   end

   task automatic a_start(input logic [9:0] sec, input bit unlk);
      @(negedge clk);
      a_sec = sec; a_unlk = unlk; a_req = 1'b1;
      if (unlk) begin
         push_exp(19'h05555, 8'hAA, "R2");
         push_exp(19'h02AAA, 8'h55, "R2");
         push_exp(19'h05555, 8'hA0, "R2");
      end
      @(negedge clk);
      a_req = 1'b0;
      chk(a_busy == 1'b1, "R7", "busy after request", a_busy, 1);
   endtask

   task automatic a_send(input logic [9:0] sec, input logic [OIW-1:0] off,
                         input logic [7:0] d, input bit last);
      @(negedge clk);
      while (!a_rdy) @(negedge clk);
      if (off < 512) push_exp({sec, off[8:0]}, d, "R3");
      a_off = off; a_dat = d; a_last = last; a_bv = 1'b1;
      @(negedge clk);
      a_bv = 1'b0; a_last = 1'b0;
      if (off < 512) chk(a_rdy == 1'b0, "R10", "ready during byte write", a_rdy, 0);
   endtask

   task automatic a_wait_done(input logic [1:0] exp_err, input int exp_delay, input string req);
      int t = 0;
      while (!a_done_hit && t < 5000) begin @(negedge clk); t++; end
      chk(a_done_hit, "R7", "done pulse seen", a_done_hit, 1);
      chk(a_done_err == exp_err, req, "error code", a_done_err, exp_err);
      chk(a_done_cyc - last_rise == exp_delay, req, "done delay after last strobe",
          a_done_cyc - last_rise, exp_delay);
      chk(qa.size() == 0, "R8", "expected writes still pending", qa.size(), 0);
      @(negedge clk);
      chk(a_busy == 1'b0, "R7", "busy after done", a_busy, 0);
      a_done_hit = 1'b0;
   endtask

   // ---------------- instance u1: 256-byte sectors ----------------
   logic b_req = 0, b_bv = 0, b_last = 0;
   logic [10:0] b_sec = '0;
   logic [OIW-1:0] b_off = '0;
   logic [7:0] b_dat = '0;
   logic b_rdy, b_busy, b_done, b_ce, b_oe, b_we;
   logic [1:0] b_err;
   logic [AW-1:0] b_maddr;
   logic [7:0] b_mdat;

   spg_sector_writer #(.SECTOR_512(1'b0), .OFFIN_W(OIW), .WE_CLKS(B_WE),
                       .GAP_MAX(B_GAP), .TWC_CLKS(B_TWC)) u1 (
      .clk(clk), .rst_n(rst_n), .req_valid_i(b_req), .req_sector_i(b_sec),
      .req_unlock_i(1'b0), .byte_valid_i(b_bv), .byte_last_i(b_last),
      .byte_offset_i(b_off), .byte_data_i(b_dat), .byte_ready_o(b_rdy),
      .busy_o(b_busy), .done_o(b_done), .err_o(b_err), .mem_addr_o(b_maddr),
      .mem_data_o(b_mdat), .mem_ce_n_o(b_ce), .mem_oe_n_o(b_oe), .mem_we_n_o(b_we));

   logic b_we_prev = 1'b1;
   int b_low = 0, b_wlow = 0, b_nwr = 0, b_rise = 0, b_dcyc = 0;
   logic [AW-1:0] b_waddr = '0;
   logic [7:0] b_wdat = '0;
   bit b_hit = 1'b0;
   logic [1:0] b_err_s = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (b_we === 1'b0) b_low++;
         if (b_we === 1'b1 && b_we_prev === 1'b0) begin
            b_nwr++; b_waddr = b_maddr; b_wdat = b_mdat; b_wlow = b_low; b_low = 0; b_rise = cyc;
         end
         if (b_done === 1'b1) begin b_hit = 1'b1; b_err_s = b_err; b_dcyc = cyc; end
         b_we_prev = b_we;
      end
   end

   task automatic b_run(input logic [10:0] sec, input logic [OIW-1:0] off,
                        input logic [7:0] d, input bit last);
      @(negedge clk);
      while (!b_rdy) @(negedge clk);
      b_off = off; b_dat = d; b_last = last; b_bv = 1'b1;
      @(negedge clk);
      b_bv = 1'b0; b_last = 1'b0;
      if (sec != b_sec) chk(1'b0, "R9", "sector drive mismatch", b_sec, sec);
   endtask

   task automatic b_wait_done;
      int t = 0;
      while (!b_hit && t < 5000) begin @(negedge clk); t++; end
      chk(b_hit, "R7", "u1 done pulse seen", b_hit, 1);
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         fails++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   // ---------------- stimulus ----------------
   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      chk(a_busy == 0 && a_done == 0 && a_rdy == 0, "R1", "status in reset",
          {a_busy, a_done, a_rdy}, 0);
      chk(a_ce == 1 && a_we == 1 && a_oe == 1, "R1", "strobes in reset",
          {a_ce, a_we, a_oe}, 3'b111);
      rst_n = 1'b1;
      @(negedge clk);
      chk(a_busy == 0 && a_rdy == 0 && a_ce == 1 && a_we == 1, "R1", "state after reset",
          {a_busy, a_rdy, a_ce, a_we}, 4'b0011);

      // R2/R3: keyed operation, offsets out of order, both ends of the sector
      a_start(10'h2C5, 1'b1);
      a_send(10'h2C5, 10'h1FF, 8'h11, 1'b0);
      a_send(10'h2C5, 10'h000, 8'h22, 1'b0);
      a_send(10'h2C5, 10'h0A3, 8'h33, 1'b1);
      a_wait_done(2'b00, A_TWC + 1, "R7");

      // R10: plain operation with a request arriving mid-load
      a_start(10'h001, 1'b0);
      a_send(10'h001, 10'h040, 8'hC3, 1'b0);
      @(negedge clk);
      a_sec = 10'h3FF; a_req = 1'b1;
      @(negedge clk);
      a_req = 1'b0;
      chk(a_busy == 1'b1, "R10", "busy kept through ignored request", a_busy, 1);
      a_send(10'h001, 10'h041, 8'h3C, 1'b1);
      a_wait_done(2'b00, A_TWC + 1, "R10");

      // R5: out-of-range offsets are dropped and flagged
      a_start(10'h155, 1'b1);
      a_send(10'h155, 10'h200, 8'h99, 1'b0);
      a_send(10'h155, 10'h3FF, 8'h98, 1'b0);
      a_send(10'h155, 10'h010, 8'h5A, 1'b1);
      a_wait_done(2'b01, A_TWC + 1, "R5");

      // R6: host stalls after one byte, highest sector number
      a_start(10'h3FF, 1'b0);
      a_send(10'h3FF, 10'h005, 8'hE7, 1'b0);
      a_wait_done(2'b10, A_GAP + A_TWC + 1, "R6");

      chk(stab_viol == 0, "R4", "address/data moved while selected", stab_viol, 0);
      chk(ce_viol == 0, "R4", "strobe without chip enable", ce_viol, 0);
      chk(oe_viol == 0, "R4", "output enable asserted", oe_viol, 0);

      // R9: alternate layout on u1
      @(negedge clk);
      b_sec = 11'h5A3; b_req = 1'b1;
      @(negedge clk);
      b_req = 1'b0;
      b_run(11'h5A3, 10'h03C, 8'h7E, 1'b1);
      b_wait_done();
      chk(b_waddr == {11'h5A3, 8'h3C}, "R9", "256-byte layout address", b_waddr, {11'h5A3, 8'h3C});
      chk(b_wdat == 8'h7E, "R9", "256-byte layout data", b_wdat, 8'h7E);
      chk(b_wlow == B_WE, "R4", "single-clock strobe width", b_wlow, B_WE);
      chk(b_err_s == 2'b00, "R9", "u1 clean error code", b_err_s, 0);
      chk(b_dcyc - b_rise == B_TWC + 1, "R7", "u1 done delay", b_dcyc - b_rise, B_TWC + 1);
      b_hit = 1'b0;

      @(negedge clk);
      b_sec = 11'h000; b_req = 1'b1;
      @(negedge clk);
      b_req = 1'b0;
      b_run(11'h000, 10'h100, 8'h01, 1'b0);
      b_run(11'h000, 10'h0FF, 8'h02, 1'b1);
      b_wait_done();
      chk(b_nwr == 2, "R5", "offset 100h dropped in 256 layout", b_nwr, 2);
      chk(b_waddr == {11'h000, 8'hFF}, "R9", "top offset address", b_waddr, {11'h000, 8'hFF});
      chk(b_err_s == 2'b01, "R5", "u1 range error", b_err_s, 2'b01);

      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule